// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides a double-width unsigned dividend by a single-width unsigned divisor over several clock cycles. It returns a single-width quotient and a single-width remainder, and it flags results that cannot fit. Work is held in one register pair. The upper half is a partial remainder, one bit wider than the divisor so that its sign can be seen. The lower half starts with the low dividend bits. As each iteration shifts the pair left, one quotient bit enters the lower half from the right.

Each iteration shifts the pair left and then either subtracts or adds the divisor. A nonnegative partial remainder gives a subtract, and a negative one gives an add. No restore step is taken. When the last iteration leaves a negative partial remainder, one closing addition of the divisor corrects it.

The block checks for overflow before it starts the loop. Overflow is declared when the upper half of the dividend is greater than or equal to the divisor, and this test also covers a zero divisor. A caller drives `start` with its operands for one cycle and then waits for the one-cycle `done` pulse.

Top module: `nrdiv_unit`

## Requirements
- R1: `start` is accepted only when `busy` is low. The operands are captured at that clock edge, and `busy` is high in the following cycle.
- R2: If the upper W bits of the dividend are greater than or equal to the divisor (this includes a zero divisor), the result has `overflow`=1, quotient=0 and remainder=0.
- R3: Otherwise `overflow`=0, quotient = floor(dividend / divisor), and remainder = dividend mod divisor.
- R4: When there is no overflow, the remainder is always less than the divisor. A negative final partial remainder is corrected by one addition of the divisor.
- R5: Take the edge that accepts `start` as edge k. `done` is high in the cycle after edge k+W+1 when there is no overflow, and in the cycle after edge k+1 when there is overflow.
- R6: `done` is high for exactly one cycle per accepted `start`.
- R7: `quotient`, `remainder` and `overflow` change only in the cycle where `done` is high, and they hold their values until the next result.
- R8: A `start` pulse while `busy` is high is ignored. The running operation finishes with the operands it captured.
- R9: While reset is active, and right after it, `busy`=0, `done`=0, `overflow`=0, and quotient and remainder are zero.
- R10: With W=4, dividend 20 (binary 00010100) and divisor 3 (binary 0011) give quotient 6 (0110) and remainder 2 (0010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a division; sampled only while idle |
| dividend | input | 2*W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | High from the cycle after acceptance until the result is ready |
| done | output | 1 | One-cycle pulse marking a fresh result |
| overflow | output | 1 | Quotient does not fit in W bits, or the divisor is zero |
| quotient | output | W | Quotient of the last division |
| remainder | output | W | Remainder of the last division |

## Verification
The checker assumes that the operands are valid only on a cycle where `start` is high and `busy` is low. It copies them at that point and ignores the operand inputs at all other times. Because of this, its reconstruction check (quotient times divisor plus remainder) and its latency counter do not depend on what the inputs do while a division is running.

The bench keeps within that assumption and also tests its edge. On selected runs it pulses `start` mid-operation with unrelated operands and changes the inputs after completion. The checker is expected to stay silent in those cases, and the bench's own arithmetic comparison shows that the intruding values had no effect.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_OVF  = 2'd3
  } nrdiv_state_e;

endpackage

// File: rtl/nrdiv_addsub.sv
// Ripple add/subtract over WIDTH bits; subtraction inverts b and injects a carry.
module nrdiv_addsub #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] carry;

  assign b_eff    = b ^ {WIDTH{sub}};
  assign carry[0] = sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = a[i] ^ b_eff[i] ^ carry[i];
    if (i < WIDTH - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end
  end

endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer: idle -> W iterations -> correction, or idle -> overflow report.
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ovf_det,
  output logic load,
  output logic step,
  output logic fix,
  output logic ovf_fin,
  output logic busy
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nrdiv_state_e state;
  logic [CW-1:0] iter;

  assign load    = (state == ST_IDLE) && start;
  assign step    = (state == ST_RUN);
  assign fix     = (state == ST_FIX);
  assign ovf_fin = (state == ST_OVF);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          iter <= '0;
          if (start) state <= ovf_det ? ST_OVF : ST_RUN;
        end
        ST_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        ST_OVF:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrdiv_datapath.sv
// Register pair (signed partial remainder : dividend/quotient) and result registers.
module nrdiv_datapath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           fix,
  input  logic           ovf_fin,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           ovf_det,
  output logic           done,
  output logic           overflow,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder
);

  localparam int PW = W + 1;

  logic [PW-1:0] part;
  logic [W-1:0]  low;
  logic [W-1:0]  dvs;
  logic [PW-1:0] shifted;
  logic [PW-1:0] opnd_a;
  logic [PW-1:0] res;
  logic          do_sub;
  logic          neg;

  assign ovf_det = dividend[2*W-1:W] >= divisor;
  assign neg     = part[PW-1];
  assign shifted = {part[W-1:0], low[W-1]};
  assign opnd_a  = step ? shifted : part;
  assign do_sub  = step & ~neg;

  nrdiv_addsub #(.WIDTH(PW)) u_addsub (
    .a   (opnd_a),
    .b   ({1'b0, dvs}),
    .sub (do_sub),
    .y   (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      part      <= '0;
      low       <= '0;
      dvs       <= '0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= fix | ovf_fin;
      if (load) begin
        part <= {1'b0, dividend[2*W-1:W]};
        low  <= dividend[W-1:0];
        dvs  <= divisor;
      end else if (step) begin
        part <= res;
        low  <= {low[W-2:0], ~res[PW-1]};
      end
      if (fix) begin
        quotient  <= low;
        remainder <= neg ? res[W-1:0] : part[W-1:0];
        overflow  <= 1'b0;
      end else if (ovf_fin) begin
        quotient  <= '0;
        remainder <= '0;
        overflow  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           overflow,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder
);

  logic load, step, fix, ovf_fin, ovf_det;

  nrdiv_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ovf_det (ovf_det),
    .load    (load),
    .step    (step),
    .fix     (fix),
    .ovf_fin (ovf_fin),
    .busy    (busy)
  );

  nrdiv_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .fix       (fix),
    .ovf_fin   (ovf_fin),
    .dividend  (dividend),
    .divisor   (divisor),
    .ovf_det   (ovf_det),
    .done      (done),
    .overflow  (overflow),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: rtl/nrdiv_unit_chk.sv
module nrdiv_unit_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [2*W-1:0] dividend,
  input logic [W-1:0]   divisor,
  input logic           busy,
  input logic           done,
  input logic           overflow,
  input logic [W-1:0]   quotient,
  input logic [W-1:0]   remainder
);

  logic [2*W-1:0] cap_dvd;
  logic [W-1:0]   cap_dvs;
  logic           cap_ovf;
  logic [15:0]    cyc;
  logic [2*W:0]   recon;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
      cap_ovf <= 1'b0;
      cyc     <= '0;
    end else if (start && !busy) begin
      cap_dvd <= dividend;
      cap_dvs <= divisor;
      cap_ovf <= dividend[2*W-1:W] >= divisor;
      cyc     <= '0;
    end else if (cyc != 16'hFFFF) begin
      cyc <= cyc + 16'd1;
    end
  end

  always_comb recon = (2*W+1)'(quotient) * (2*W+1)'(cap_dvs) + (2*W+1)'(remainder);

  a_r1_busy_follows: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r2_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (overflow == cap_ovf));
  a_r2_ovf_zero: assert property (@(posedge clk) disable iff (rst)
    (done && overflow) |-> (quotient == '0 && remainder == '0));
  a_r3_reconstruct: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow) |-> (recon == {1'b0, cap_dvd}));
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (rst)
    (done && !overflow) |-> (remainder < cap_dvs));
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (cyc == (cap_ovf ? 16'd1 : 16'(W + 1))));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({quotient, remainder, overflow}) |-> done);

endmodule

bind nrdiv_unit nrdiv_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .overflow  (overflow),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/nrdiv_unit_test.sv
`timescale 1ns/1ps
module nrdiv_unit_test;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic           busy, done, overflow;
  logic [W-1:0]   quotient, remainder;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nrdiv_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .overflow(overflow),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One division; poke=1 fires an intruding start while busy (R8).
  task automatic run_op(input int dvd, input int dvs, input bit poke);
    int exp_q, exp_r, lat, exp_lat;
    bit exp_o;
    logic [W-1:0] hq, hr;
    logic ho;
    exp_o   = (dvd >> W) >= dvs;
    exp_q   = exp_o ? 0 : dvd / dvs;
    exp_r   = exp_o ? 0 : dvd % dvs;
    exp_lat = exp_o ? 2 : W + 2;
    @(negedge clk);
    dividend = (2*W)'(dvd);
    divisor  = W'(dvs);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after accept", busy, 1);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 2 && !done) begin
        start    = 1'b1;
        dividend = ~dividend;
        divisor  = divisor + 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(lat == exp_lat, "R5", "latency", lat, exp_lat);
    check(overflow == exp_o, exp_o ? "R2" : "R3", "overflow", overflow, exp_o);
    check(quotient == W'(exp_q), poke ? "R8" : (exp_o ? "R2" : "R3"), "quotient",
          quotient, exp_q);
    check(remainder == W'(exp_r), exp_o ? "R2" : "R4", "remainder", remainder, exp_r);
    hq = quotient; hr = remainder; ho = overflow;
    dividend = ~dividend;
    divisor  = ~divisor;
    @(negedge clk);
    check(done == 1'b0, "R6", "done pulse width", done, 0);
    check(busy == 1'b0, "R1", "idle after done", busy, 0);
    check({quotient, remainder, ho} == {hq, hr, overflow}, "R7", "result hold",
          {quotient, remainder}, {hq, hr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0 && done == 1'b0, "R9", "control in reset", {busy, done}, 0);
    check(overflow == 1'b0 && quotient == '0 && remainder == '0, "R9",
          "outputs in reset", {overflow, quotient, remainder}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && quotient == '0, "R9", "after reset",
          {busy, done, quotient}, 0);

    // R10: worked example 20 / 3
    run_op(20, 3, 1'b0);
    check(quotient == 4'b0110 && remainder == 4'b0010, "R10", "example q:r",
          {quotient, remainder}, 8'b0110_0010);

    // R2..R8: exhaustive sweep over every dividend and divisor
    for (int d = 0; d < (1 << W); d++) begin
      for (int n = 0; n < (1 << (2*W)); n++) begin
        run_op(n, d, (n % 7) == 3);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule